// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when a small 8-bit controller core and its peripherals are held in reset, and it records why. Five causes feed it: the power-on pulse, the low-supply comparator flag, an on-block watchdog counter that the software has to keep clearing, an illegal-opcode strobe from the decoder (a stop instruction executed while stop is not enabled counts as one), and a strobe for a fetch from an unmapped address. The unmapped-fetch strobe counts only when the fetch is an opcode fetch. The block drives an active-low reset pin value, meant for an open-drain pad, and a clock-enable that gates the CPU and module clocks.

After power-on, or once the supply recovers, the clocks stay gated for an oscillator settling window (OSC_CYC cycles of the 4x bus clock). The reset pin is then held low for a further PIN_CYC cycles with the clocks running. Internal causes skip the settling window and use only the pin window. A new internal cause that arrives during the pin window starts that window again. A five-bit status register holds one sticky flag per cause. Power-on sets its own flag and clears all the others. Reading the register clears the flags, but a cause that fires in the same cycle as the read keeps its flag.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_req` is sampled high, the next cycle shows `rst_pin_n`=0, `clk_en`=0 and `stat_q`=5'b00001. The flag bits are [0] power-on, [1] low supply, [2] watchdog, [3] illegal opcode and [4] illegal fetch address.
- R2: Take the last edge at which `por_req` is high as edge P. `clk_en` becomes 1 after edge P+OSC_CYC (4096 by default), and `rst_pin_n` is still 0 at that point.
- R3: `rst_pin_n` becomes 1 PIN_CYC (32) edges after `clk_en` became 1. `rst_pin_n` is never 1 while `clk_en` is 0.
- R4: While `lowv_flag` is 1, the next cycle has `rst_pin_n`=0, `clk_en`=0 and flag [1] set. Take the first edge at which the flag is sampled 0 as edge L. `clk_en` rises after edge L+OSC_CYC and `rst_pin_n` rises after edge L+OSC_CYC+PIN_CYC.
- R5: While the pin is released, the watchdog counts each cycle in which `wdog_kick` is 0. With no kick, the watchdog fires 2^WDOG_W (1024) edges after the last kicked edge. It sets flag [2] and drives `rst_pin_n` low for PIN_CYC cycles, and `clk_en` stays 1.
- R6: A cycle with `wdog_kick`=1 clears the watchdog count. Kicking more often than every 2^WDOG_W cycles never causes a reset.
- R7: `illegal_op` while `clk_en`=1 sets flag [3] and drives `rst_pin_n` low on the next cycle for PIN_CYC cycles.
- R8: `stop_dec` while `clk_en`=1 acts like `illegal_op` when `stop_en`=0. It has no effect on the pin or the flags when `stop_en`=1.
- R9: `fetch_unmapped` with `fetch_is_opcode`=1 while `clk_en`=1 sets flag [4] and starts the PIN_CYC pin window. With `fetch_is_opcode`=0 it has no effect.
- R10: Flags stay set until a cycle with `stat_rd`=1, which clears them all at that edge. A cause that fires in the same cycle keeps its flag set.
- R11: An internal cause that arrives while the pin window is running restarts the window, so `rst_pin_n` rises PIN_CYC edges after the last such cause.
- R12: While `clk_en` is 0, the watchdog, illegal-opcode and illegal-fetch causes are ignored. Flags [2]..[4] do not change and the sequence timing does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4x bus clock |
| por_req | input | 1 | Power-on pulse, synchronous active-high; also the block reset |
| lowv_flag | input | 1 | Supply below trip point |
| wdog_kick | input | 1 | Write to the watchdog control location |
| illegal_op | input | 1 | Undefined opcode decoded |
| stop_dec | input | 1 | Stop instruction decoded |
| stop_en | input | 1 | Configuration bit allowing the stop instruction |
| fetch_unmapped | input | 1 | Access to an unmapped address |
| fetch_is_opcode | input | 1 | The access is an opcode fetch |
| stat_rd | input | 1 | Read strobe for the status register |
| stat_q | output | 5 | Reset cause flags |
| clk_en | output | 1 | CPU and module clock enable, registered |
| rst_pin_n | output | 1 | Reset pin value, 0 = drive low, registered |

## Verification
Every result comes from a single register stage. Flags and pin changes caused by a stimulus appear one edge after the cycle in which it is sampled. The clock enable rises exactly OSC_CYC edges after the sequence starts, the pin rises PIN_CYC edges after that, and the watchdog fires 2^WDOG_W edges after its last kick. The bench drives inputs on the falling edge and counts falling edges from a known start. It checks each boundary one cycle before the expected change (still low) and at the change itself (now high), so an off-by-one error in any counter shows up.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_LOWV = 2'd1,
    SQ_OSC  = 2'd2,
    SQ_PIN  = 2'd3
  } seq_state_e;

  localparam int FLAG_N = 5;
  localparam int F_POR  = 0;
  localparam int F_LVI  = 1;
  localparam int F_COP  = 2;
  localparam int F_ILOP = 3;
  localparam int F_ILAD = 4;
endpackage

// File: rtl/rst_wdog.sv
module rst_wdog #(
  parameter int WDOG_W = 10
) (
  input  logic clk,
  input  logic hold,
  input  logic kick,
  output logic ovf
);
  localparam logic [WDOG_W-1:0] TOP = '1;

  logic [WDOG_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (hold || kick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign ovf = !hold && !kick && (cnt == TOP);
endmodule

// File: rtl/rst_cause_collect.sv
module rst_cause_collect
  import rst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              por_req,
  input  logic              lowv_flag,
  input  logic              clk_on,
  input  logic              cop_ovf,
  input  logic              illegal_op,
  input  logic              stop_dec,
  input  logic              stop_en,
  input  logic              fetch_unmapped,
  input  logic              fetch_is_opcode,
  input  logic              stat_rd,
  output logic              int_req,
  output logic [FLAG_N-1:0] stat_q
);
  logic [FLAG_N-1:0] set_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[F_LVI]  = lowv_flag;
    set_vec[F_COP]  = cop_ovf;
    set_vec[F_ILOP] = clk_on && (illegal_op || (stop_dec && !stop_en));
    set_vec[F_ILAD] = clk_on && fetch_unmapped && fetch_is_opcode;
  end

  assign int_req = set_vec[F_COP] | set_vec[F_ILOP] | set_vec[F_ILAD];

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (por_req)         stat_q[i] <= (i == F_POR);
      else if (set_vec[i]) stat_q[i] <= 1'b1;
      else if (stat_rd)    stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int OSC_CYC = 4096,
  parameter int PIN_CYC = 32
) (
  input  logic clk,
  input  logic por_req,
  input  logic lowv_flag,
  input  logic int_req,
  output logic clk_en,
  output logic rst_pin_n
);
  localparam int MAXC  = (OSC_CYC > PIN_CYC) ? OSC_CYC : PIN_CYC;
  localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] OSC_LAST = CNT_W'(OSC_CYC - 1);
  localparam logic [CNT_W-1:0] PIN_LAST = CNT_W'(PIN_CYC - 1);

  seq_state_e       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (lowv_flag) begin
      st_n  = SQ_LOWV;
      cnt_n = '0;
    end else begin
      unique case (st)
        SQ_LOWV: begin
          st_n  = SQ_OSC;
          cnt_n = '0;
        end
        SQ_OSC: begin
          if (cnt == OSC_LAST) begin
            st_n  = SQ_PIN;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        SQ_PIN: begin
          if (int_req) begin
            cnt_n = '0;
          end else if (cnt == PIN_LAST) begin
            st_n  = SQ_RUN;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        default: begin
          if (int_req) begin
            st_n  = SQ_PIN;
            cnt_n = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_req) begin
      st        <= SQ_OSC;
      cnt       <= '0;
      clk_en    <= 1'b0;
      rst_pin_n <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      clk_en    <= (st_n == SQ_RUN) || (st_n == SQ_PIN);
      rst_pin_n <= (st_n == SQ_RUN);
    end
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int OSC_CYC = 4096,
  parameter int PIN_CYC = 32,
  parameter int WDOG_W  = 10
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              lowv_flag,
  input  logic              wdog_kick,
  input  logic              illegal_op,
  input  logic              stop_dec,
  input  logic              stop_en,
  input  logic              fetch_unmapped,
  input  logic              fetch_is_opcode,
  input  logic              stat_rd,
  output logic [FLAG_N-1:0] stat_q,
  output logic              clk_en,
  output logic              rst_pin_n
);
  logic cop_ovf;
  logic int_req;
  logic wd_hold;

  assign wd_hold = por_req || !rst_pin_n;

  rst_wdog #(.WDOG_W(WDOG_W)) u_wdog (
    .clk  (clk),
    .hold (wd_hold),
    .kick (wdog_kick),
    .ovf  (cop_ovf)
  );

  rst_cause_collect u_cause (
    .clk             (clk),
    .por_req         (por_req),
    .lowv_flag       (lowv_flag),
    .clk_on          (clk_en),
    .cop_ovf         (cop_ovf),
    .illegal_op      (illegal_op),
    .stop_dec        (stop_dec),
    .stop_en         (stop_en),
    .fetch_unmapped  (fetch_unmapped),
    .fetch_is_opcode (fetch_is_opcode),
    .stat_rd         (stat_rd),
    .int_req         (int_req),
    .stat_q          (stat_q)
  );

  rst_seq_fsm #(.OSC_CYC(OSC_CYC), .PIN_CYC(PIN_CYC)) u_fsm (
    .clk       (clk),
    .por_req   (por_req),
    .lowv_flag (lowv_flag),
    .int_req   (int_req),
    .clk_en    (clk_en),
    .rst_pin_n (rst_pin_n)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       por_req,
  input logic       lowv_flag,
  input logic       illegal_op,
  input logic       fetch_unmapped,
  input logic       fetch_is_opcode,
  input logic       stat_rd,
  input logic [4:0] stat_q,
  input logic       clk_en,
  input logic       rst_pin_n
);
  // R1
  por_state_chk: assert property (@(posedge clk)
    por_req |=> (!rst_pin_n && !clk_en && stat_q == 5'b00001));

  // R3
  pin_after_clk_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(rst_pin_n) |-> (clk_en && $stable(clk_en)));

  // R4
  lowv_hold_chk: assert property (@(posedge clk) disable iff (por_req)
    lowv_flag |=> (!rst_pin_n && !clk_en && stat_q[1]));

  // R7
  ilop_chk: assert property (@(posedge clk) disable iff (por_req)
    (clk_en && !lowv_flag && illegal_op) |=> (stat_q[3] && !rst_pin_n && clk_en));

  // R9
  ilad_chk: assert property (@(posedge clk) disable iff (por_req)
    (clk_en && !lowv_flag && fetch_unmapped && fetch_is_opcode) |=> (stat_q[4] && !rst_pin_n));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (por_req)
    (stat_rd && !clk_en && !lowv_flag) |=> (stat_q == 5'b00000));

  // R12
  masked_chk: assert property (@(posedge clk) disable iff (por_req)
    (!clk_en && !stat_rd) |=> $stable(stat_q[4:2]));
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk             (clk),
  .por_req         (por_req),
  .lowv_flag       (lowv_flag),
  .illegal_op      (illegal_op),
  .fetch_unmapped  (fetch_unmapped),
  .fetch_is_opcode (fetch_is_opcode),
  .stat_rd         (stat_rd),
  .stat_q          (stat_q),
  .clk_en          (clk_en),
  .rst_pin_n       (rst_pin_n)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
  localparam int OSC_CYC = 4096;
  localparam int PIN_CYC = 32;
  localparam int WDOG_W  = 10;
  localparam int WD_FIRE = 1 << WDOG_W;

  logic clk = 1'b0;
  logic por_req = 1'b1;
  logic lowv_flag = 1'b0;
  logic wdog_kick = 1'b1;
  logic illegal_op = 1'b0;
  logic stop_dec = 1'b0;
  logic stop_en = 1'b1;
  logic fetch_unmapped = 1'b0;
  logic fetch_is_opcode = 1'b0;
  logic stat_rd = 1'b0;
  logic [4:0] stat_q;
  logic clk_en;
  logic rst_pin_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.OSC_CYC(OSC_CYC), .PIN_CYC(PIN_CYC), .WDOG_W(WDOG_W)) u0 (
    .clk(clk), .por_req(por_req), .lowv_flag(lowv_flag), .wdog_kick(wdog_kick),
    .illegal_op(illegal_op), .stop_dec(stop_dec), .stop_en(stop_en),
    .fetch_unmapped(fetch_unmapped), .fetch_is_opcode(fetch_is_opcode),
    .stat_rd(stat_rd), .stat_q(stat_q), .clk_en(clk_en), .rst_pin_n(rst_pin_n)
  );

  // {illegal_op, stop_dec, stop_en, fetch_unmapped, fetch_is_opcode, exp_flags[4:0], exp_pulse}
  localparam logic [10:0] VEC [6] = '{
    {5'b10100, 5'b01000, 1'b1},
    {5'b01000, 5'b01000, 1'b1},
    {5'b01100, 5'b00000, 1'b0},
    {5'b00111, 5'b10000, 1'b1},
    {5'b00110, 5'b00000, 1'b0},
    {5'b10111, 5'b11000, 1'b1}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    tick(5);
    chk("R1 pin", 32'(rst_pin_n), 0);
    chk("R1 clk_en", 32'(clk_en), 0);
    chk("R1 stat", 32'(stat_q), 32'h01);
    por_req = 1'b0;
    tick(100);
    illegal_op = 1'b1; fetch_unmapped = 1'b1; fetch_is_opcode = 1'b1;
    tick();
    illegal_op = 1'b0; fetch_unmapped = 1'b0; fetch_is_opcode = 1'b0;
    chk("R12 masked stat", 32'(stat_q), 32'h01);
    chk("R12 masked clk_en", 32'(clk_en), 0);
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    chk("R10 read clears", 32'(stat_q), 0);
    tick(OSC_CYC - 1 - 102);
    chk("R2 clk_en before", 32'(clk_en), 0);
    tick();
    chk("R2 clk_en at", 32'(clk_en), 1);
    chk("R2 pin still low", 32'(rst_pin_n), 0);
    tick(PIN_CYC - 1);
    chk("R3 pin before", 32'(rst_pin_n), 0);
    tick();
    chk("R3 pin at", 32'(rst_pin_n), 1);

    for (int v = 0; v < 6; v++) begin
      logic [4:0] ef;
      logic ep;
      stat_rd = 1'b1;
      tick();
      stat_rd = 1'b0;
      {illegal_op, stop_dec, stop_en, fetch_unmapped, fetch_is_opcode} = VEC[v][10:6];
      ef = VEC[v][5:1];
      ep = VEC[v][0];
      tick();
      illegal_op = 1'b0; stop_dec = 1'b0; stop_en = 1'b1;
      fetch_unmapped = 1'b0; fetch_is_opcode = 1'b0;
      chk("R7 R8 R9 table stat", 32'(stat_q), 32'(ef));
      chk("R7 R8 R9 table pin", 32'(rst_pin_n), 32'(!ep));
      chk("R7 table clk_en", 32'(clk_en), 1);
      if (ep) begin
        tick(PIN_CYC - 1);
        chk("R7 pulse still low", 32'(rst_pin_n), 0);
        chk("R10 sticky", 32'(stat_q), 32'(ef));
        tick();
        chk("R7 pulse ends", 32'(rst_pin_n), 1);
      end else begin
        tick(3);
        chk("R8 R9 no effect", 32'(rst_pin_n), 1);
      end
    end

    stat_rd = 1'b1; illegal_op = 1'b1;
    tick();
    stat_rd = 1'b0; illegal_op = 1'b0;
    chk("R10 set beats clear", 32'(stat_q), 32'h08);
    tick(PIN_CYC);
    chk("R10 pin back", 32'(rst_pin_n), 1);

    illegal_op = 1'b1;
    tick();
    illegal_op = 1'b0;
    tick(9);
    illegal_op = 1'b1;
    tick();
    illegal_op = 1'b0;
    tick(PIN_CYC - 1);
    chk("R11 restart low", 32'(rst_pin_n), 0);
    tick();
    chk("R11 restart high", 32'(rst_pin_n), 1);

    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    wdog_kick = 1'b0;
    tick(WD_FIRE - 1);
    chk("R5 before fire", 32'(rst_pin_n), 1);
    tick();
    chk("R5 fired pin", 32'(rst_pin_n), 0);
    chk("R5 clk_en kept", 32'(clk_en), 1);
    chk("R5 flag", 32'(stat_q), 32'h04);
    wdog_kick = 1'b1;
    tick(PIN_CYC - 1);
    chk("R5 pulse low", 32'(rst_pin_n), 0);
    tick();
    chk("R5 pulse end", 32'(rst_pin_n), 1);

    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    wdog_kick = 1'b0;
    tick(WD_FIRE - 30);
    wdog_kick = 1'b1;
    tick();
    wdog_kick = 1'b0;
    tick(WD_FIRE - 30);
    chk("R6 kicked pin", 32'(rst_pin_n), 1);
    chk("R6 kicked stat", 32'(stat_q), 0);
    wdog_kick = 1'b1;

    lowv_flag = 1'b1;
    tick();
    chk("R4 low pin", 32'(rst_pin_n), 0);
    chk("R4 low clk_en", 32'(clk_en), 0);
    chk("R4 flag", 32'(stat_q[1]), 1);
    illegal_op = 1'b1;
    tick();
    illegal_op = 1'b0;
    chk("R12 ignored in lowv", 32'(stat_q[3]), 0);
    tick(3);
    lowv_flag = 1'b0;
    tick(OSC_CYC);
    chk("R4 clk_en before", 32'(clk_en), 0);
    tick();
    chk("R4 clk_en at", 32'(clk_en), 1);
    chk("R4 pin low", 32'(rst_pin_n), 0);
    tick(PIN_CYC - 1);
    chk("R4 pin before", 32'(rst_pin_n), 0);
    tick();
    chk("R4 pin at", 32'(rst_pin_n), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule